// File: doc/BRIEF.md
# Read-Triggered ADC Conversion Controller

This block sits between a CPU bus and a sampling analog-to-digital converter core. Software polls one result register. Each read returns the newest 16-bit sample together with a completion flag. The same read also serves as the start command: when the controller is idle and the settling interval has run out, the read launches the next conversion. A read that lands while a conversion runs changes nothing, so the result that conversion produces is not affected.

The converter core runs from a clock-enable pulse derived from the system clock. The divide ratio is 4 or 16 and comes from a configuration bit. After every finished conversion a hardware down-counter holds off the next start for a set number of converter ticks. That spares software from timing the settling gap itself. A second configuration bit makes reads return the sample sign-extended, for codes that are two's complement around mid-scale.

Top module: `adc_rdconv`

## Requirements
- R1: After synchronous reset `rdData` is 0, `convStart` is 0, the converter is idle and the settling counter is 0.
- R2: A cycle with `rdEn` high, no conversion running and the settling counter at 0 produces a one-cycle `convStart` pulse in the following cycle.
- R3: `rdData[31]` is the status flag and `rdData[15:0]` the latest result. With the signed bit clear, `rdData[30:16]` are 0.
- R4: When configuration bit 0 (signed mode) is 1, `rdData[30:16]` all equal `rdData[15]`.
- R5: The status flag is 1 only when a completed sample is held and the settling counter is 0. It reads 0 while a conversion runs and during settling.
- R6: A read while a conversion runs does not produce a new `convStart` and does not change the result that conversion delivers.
- R7: `convDone` while converting loads `convCode` into the result. `convDone` while idle is ignored.
- R8: `convClkEn` pulses for one cycle every 4 system cycles when configuration bit 16 is 0, and every 16 when it is 1. A configuration write restarts the divide count.
- R9: Completion loads the settling counter with SETTLE_FAST (bit 16 = 0) or SETTLE_SLOW (bit 16 = 1). The counter drops by one per `convClkEn`. Reads while it is nonzero start nothing.
- R10: The status flag clears at the clock edge that starts a new conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rdEn | input | 1 | CPU read strobe for the result register |
| rdData | output | 32 | Status in bit 31, result in bits 15:0 |
| cfgWrEn | input | 1 | Configuration register write strobe |
| cfgWrData | input | 32 | Bit 16 selects divide-by-16, bit 0 selects signed reads |
| convClkEn | output | 1 | Converter clock-enable pulse |
| convStart | output | 1 | One-cycle conversion start to the core |
| convDone | input | 1 | Core completion pulse |
| convCode | input | 16 | Core output code, valid with convDone |

## Verification
The bench goes after reads that arrive mid-conversion. A design that restarted on them would pulse `convStart` again, and the core would then deliver its code late. It also reads during the settling window. If the hold-off were missing, a start would fire early and the status flag would read 1 too soon. A `convDone` is driven while the controller is idle, which catches a design that overwrites the held sample. Signed and unsigned reads of the negative code 0x9E58 and of 0x8001 expose a wrong extension, and a divider stuck at one ratio shows up as the wrong tick count after reconfiguration.

// File: rtl/adc_rdconv_pkg.sv
package adc_rdconv_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic start;    // conversion launched this cycle
    logic capture;  // core finished, take its code
  } ctrlStrb_t;

endpackage

// File: rtl/adc_rdconv_ctrl.sv
module adc_rdconv_ctrl
  import adc_rdconv_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      rdEn,
  input  logic      convDone,
  input  logic      settleZero,
  output ctrlStrb_t strb,
  output logic      busy,
  output logic      convStart
);

  typedef enum logic {IDLE, CONV} convState_t;
  convState_t state;

  always_comb begin
    strb.start   = rdEn && (state == IDLE) && settleZero;
    strb.capture = (state == CONV) && convDone;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= IDLE;
      convStart <= 1'b0;
    end else begin
      convStart <= strb.start;
      if (strb.start)        state <= CONV;
      else if (strb.capture) state <= IDLE;
    end
  end

  assign busy = (state == CONV);

  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    strb.start |=> (convStart && busy));

  // R6
  done_end_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && convDone) |=> (!busy && !convStart));

endmodule

// File: rtl/adc_rdconv_dp.sv
module adc_rdconv_dp
  import adc_rdconv_pkg::*;
#(
  parameter int DIV_FAST    = 4,
  parameter int DIV_SLOW    = 16,
  parameter int SETTLE_FAST = 1843,
  parameter int SETTLE_SLOW = 1843,
  parameter int RES_W       = 16,
  parameter int DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrb_t         strb,
  input  logic              cfgWrEn,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic [RES_W-1:0]  convCode,
  output logic              convClkEn,
  output logic              settleZero,
  output logic [DATA_W-1:0] rdData
);

  localparam int DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int DIV_W   = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;
  localparam int SET_MAX = (SETTLE_SLOW > SETTLE_FAST) ? SETTLE_SLOW : SETTLE_FAST;
  localparam int SET_W   = $clog2(SET_MAX + 1);
  localparam int EXT_W   = DATA_W - 1 - RES_W;
  localparam int DIVSEL_BIT = 16;
  localparam int SIGNED_BIT = 0;

  logic             divSel;
  logic             signedMode;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLim;
  logic [SET_W-1:0] settleCnt;
  logic [SET_W-1:0] settleLoad;
  logic [RES_W-1:0] resultReg;
  logic             validReg;
  logic [EXT_W-1:0] extBits;
  logic             unusedCfg;

  assign unusedCfg = ^{cfgWrData[DATA_W-1:DIVSEL_BIT+1],
                       cfgWrData[DIVSEL_BIT-1:SIGNED_BIT+1]};

  // configuration register
  always_ff @(posedge clk) begin
    if (rst) begin
      divSel     <= 1'b0;
      signedMode <= 1'b0;
    end else if (cfgWrEn) begin
      divSel     <= cfgWrData[DIVSEL_BIT];
      signedMode <= cfgWrData[SIGNED_BIT];
    end
  end

  // clock-enable divider
  assign divLim    = divSel ? DIV_W'(DIV_SLOW - 1) : DIV_W'(DIV_FAST - 1);
  assign convClkEn = (divCnt >= divLim);

  always_ff @(posedge clk) begin
    if (rst || cfgWrEn)  divCnt <= '0;
    else if (convClkEn)  divCnt <= '0;
    else                 divCnt <= divCnt + 1'b1;
  end

  // settling hold-off counter in converter ticks
  assign settleLoad = divSel ? SET_W'(SETTLE_SLOW) : SET_W'(SETTLE_FAST);
  assign settleZero = (settleCnt == '0);

  always_ff @(posedge clk) begin
    if (rst)                            settleCnt <= '0;
    else if (strb.capture)              settleCnt <= settleLoad;
    else if (convClkEn && !settleZero)  settleCnt <= settleCnt - 1'b1;
  end

  // result and valid flag
  always_ff @(posedge clk) begin
    if (rst) begin
      resultReg <= '0;
      validReg  <= 1'b0;
    end else if (strb.start) begin
      validReg  <= 1'b0;
    end else if (strb.capture) begin
      resultReg <= convCode;
      validReg  <= 1'b1;
    end
  end

  // read data formatting
  generate
    if (EXT_W > 0) begin : g_ext
      assign extBits = signedMode ? {EXT_W{resultReg[RES_W-1]}} : '0;
      assign rdData  = {validReg && settleZero, extBits, resultReg};
    end else begin : g_noext
      assign extBits = '0;
      assign rdData  = {validReg && settleZero, resultReg};
    end
  endgenerate

  // R9
  settle_block_chk: assert property (@(posedge clk) disable iff (rst)
    !settleZero |-> !strb.start);

  // R10
  valid_clear_chk: assert property (@(posedge clk) disable iff (rst)
    strb.start |=> !rdData[DATA_W-1]);

  // R7
  capture_load_chk: assert property (@(posedge clk) disable iff (rst)
    strb.capture |=> (rdData[RES_W-1:0] == $past(convCode)));

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.capture |=> $stable(rdData[RES_W-1:0]));

  // R8
  tick_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    convClkEn |=> !convClkEn);

endmodule

// File: rtl/adc_rdconv.sv
module adc_rdconv
  import adc_rdconv_pkg::*;
#(
  parameter int DIV_FAST    = 4,
  parameter int DIV_SLOW    = 16,
  parameter int SETTLE_FAST = 1843,
  parameter int SETTLE_SLOW = 1843
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rdEn,
  output logic [31:0] rdData,
  input  logic        cfgWrEn,
  input  logic [31:0] cfgWrData,
  output logic        convClkEn,
  output logic        convStart,
  input  logic        convDone,
  input  logic [15:0] convCode
);

  ctrlStrb_t strb;
  logic      busy;
  logic      settleZero;

  adc_rdconv_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .rdEn       (rdEn),
    .convDone   (convDone),
    .settleZero (settleZero),
    .strb       (strb),
    .busy       (busy),
    .convStart  (convStart)
  );

  adc_rdconv_dp #(
    .DIV_FAST    (DIV_FAST),
    .DIV_SLOW    (DIV_SLOW),
    .SETTLE_FAST (SETTLE_FAST),
    .SETTLE_SLOW (SETTLE_SLOW),
    .RES_W       (16),
    .DATA_W      (32)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .cfgWrEn    (cfgWrEn),
    .cfgWrData  (cfgWrData),
    .convCode   (convCode),
    .convClkEn  (convClkEn),
    .settleZero (settleZero),
    .rdData     (rdData)
  );

  // R5
  status_idle_chk: assert property (@(posedge clk) disable iff (rst)
    rdData[31] |-> !busy);

endmodule

// File: tb/adc_rdconv_bench.sv
module adc_rdconv_bench;

  localparam int S_FAST = 6;
  localparam int S_SLOW = 3;
  localparam int CORE_TICKS = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rdEn = 1'b0;
  logic [31:0] rdData;
  logic        cfgWrEn = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic        convClkEn;
  logic        convStart;
  logic        convDone = 1'b0;
  logic [15:0] convCode = '0;

  always #4 clk = ~clk;

  adc_rdconv #(
    .DIV_FAST(4), .DIV_SLOW(16), .SETTLE_FAST(S_FAST), .SETTLE_SLOW(S_SLOW)
  ) u_adc_rdconv (
    .clk(clk), .rst(rst), .rdEn(rdEn), .rdData(rdData),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .convClkEn(convClkEn), .convStart(convStart),
    .convDone(convDone), .convCode(convCode)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // core stub
  logic [15:0] codeQ[$];
  int stubRem = 0;
  bit spurious = 0;
  logic [15:0] spurCode = '0;

  // reference model
  int mDivCnt = 0, mSettle = 0;
  bit mDivSel = 0, mSigned = 0, mBusy = 0, mValid = 0, mStartOut = 0;
  logic [15:0] mResult = '0;
  int startSeen = 0;

  function automatic logic [31:0] modelRd();
    logic [14:0] ext;
    ext = (mSigned && mResult[15]) ? 15'h7fff : 15'h0;
    return {(mValid && mSettle == 0), ext, mResult};
  endfunction

  function automatic bit modelTick();
    return mDivCnt >= ((mDivSel ? 16 : 4) - 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    bit tick, start, cap;
    logic dn;
    logic [15:0] cd;
    dn = 1'b0;
    cd = convCode;
    if (rst) stubRem = 0;
    else if (convStart) stubRem = CORE_TICKS;
    else if (stubRem > 0 && convClkEn) begin
      stubRem--;
      if (stubRem == 0) begin
        dn = 1'b1;
        cd = (codeQ.size() > 0) ? codeQ.pop_front() : 16'h0;
      end
    end
    if (spurious) begin dn = 1'b1; cd = spurCode; end
    convDone = dn;
    convCode = cd;
    if (rst) begin
      mDivCnt = 0; mSettle = 0; mDivSel = 0; mSigned = 0;
      mBusy = 0; mValid = 0; mStartOut = 0; mResult = '0;
    end else begin
      tick  = modelTick();
      start = rdEn && !mBusy && mSettle == 0;
      cap   = mBusy && dn;
      if (cap) mSettle = mDivSel ? S_SLOW : S_FAST;
      else if (tick && mSettle > 0) mSettle--;
      mDivCnt = (cfgWrEn || tick) ? 0 : mDivCnt + 1;
      if (start) begin mBusy = 1; mValid = 0; end
      else if (cap) begin mBusy = 0; mValid = 1; mResult = cd; end
      mStartOut = start;
      if (cfgWrEn) begin mDivSel = cfgWrData[16]; mSigned = cfgWrData[0]; end
    end
    @(posedge clk);
    @(negedge clk);
    if (convStart) startSeen++;
    chk(rdData == modelRd(), "model rdData R3 R4 R5 R7", rdData, modelRd());
    chk(convStart == mStartOut, "model convStart R2 R6 R9", 32'(convStart), 32'(mStartOut));
    chk(convClkEn == modelTick(), "model convClkEn R8", 32'(convClkEn), 32'(modelTick()));
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic doRead(output logic [31:0] got);
    rdEn = 1'b1;
    got = rdData;
    cyc();
    rdEn = 1'b0;
  endtask

  task automatic cfgWrite(input logic [31:0] d);
    cfgWrEn = 1'b1;
    cfgWrData = d;
    cyc();
    cfgWrEn = 1'b0;
  endtask

  task automatic countTicks(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      if (convClkEn) cnt++;
      cyc();
    end
  endtask

  initial begin
    logic [31:0] got;
    int n, s0;
    @(negedge clk);
    waitN(3);
    // R1
    chk(rdData == 32'h0, "R1 reset rdData", rdData, 32'h0);
    chk(convStart == 1'b0, "R1 reset convStart", 32'(convStart), 32'h0);
    rst = 1'b0;
    countTicks(32, n);
    chk(n == 8, "R8 divide by 4 tick count", n, 8);

    codeQ.push_back(16'h61A8);
    doRead(got);
    // R2 convStart follows the read
    chk(convStart == 1'b1, "R2 start pulse", 32'(convStart), 32'h1);
    // R10
    chk(rdData[31] == 1'b0, "R10 status cleared on start", 32'(rdData[31]), 32'h0);
    s0 = startSeen;
    for (int i = 0; i < 6; i++) doRead(got);
    waitN(24);
    chk(startSeen == s0, "R6 no restart during conversion", startSeen - s0, 0);
    chk(rdData[15:0] == 16'h61A8, "R7 result captured", rdData[15:0], 16'h61A8);
    chk(rdData[31] == 1'b0, "R5 status low while settling", 32'(rdData[31]), 32'h0);
    s0 = startSeen;
    doRead(got);
    waitN(2);
    chk(startSeen == s0, "R9 read during settle ignored", startSeen - s0, 0);
    waitN(30);
    chk(rdData == 32'h800061A8, "R3 R5 unsigned valid read", rdData, 32'h800061A8);

    spurious = 1; spurCode = 16'h1234;
    cyc();
    spurious = 0;
    waitN(2);
    chk(rdData == 32'h800061A8, "R7 idle done ignored", rdData, 32'h800061A8);

    cfgWrite(32'h0001_0001);
    countTicks(64, n);
    chk(n == 4, "R8 divide by 16 tick count", n, 4);
    codeQ.push_back(16'h9E58);
    doRead(got);
    chk(got == 32'h800061A8, "R3 trigger read returns prior sample", got, 32'h800061A8);
    waitN(100);
    chk(rdData[31] == 1'b0, "R9 slow settle still active", 32'(rdData[31]), 32'h0);
    waitN(60);
    chk(rdData == 32'hFFFF9E58, "R4 signed read", rdData, 32'hFFFF9E58);

    codeQ.push_back(16'h8001);
    doRead(got);
    chk(got == 32'hFFFF9E58, "R4 trigger read signed value", got, 32'hFFFF9E58);
    cfgWrite(32'h0001_0000);
    waitN(160);
    chk(rdData == 32'h80008001, "R3 unsigned negative code", rdData, 32'h80008001);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule